// File: doc/BRIEF.md
# Programmable Display Write Cycle Generator

This block takes pixels from an internal valid/ready stream and turns each one into write cycles on a parallel display bus of the 80 style. For every transfer it drives the command/data select line, the active-low chip select, the active-low write strobe and the data lines. The timing of each transfer is set by two register inputs. One gives the strobe width in clocks. The other gives the hold time after the strobe rises, in clocks.

Pixels arrive as RGB565. A format select picks one of three outputs. The first sends the raw 16-bit word. The second widens the pixel to RGB666 and sends all 18 bits at once, with the two extra bits on a separate extension bus. The third sends the widened pixel as two 9-bit transfers. The bidirectional display lines are shown as a value plus an output-enable pair.

Top module: `disp_wr_gen`

## Requirements
- R1: When idle, including after reset: cs_n_o=1, wr_n_o=1, dc_o=0, d_oe_o=0, ext_oe_o=0, d_o=0, ext_o=0 and pix_ready_o=1.
- R2: Each transfer starts with exactly one setup clock: cs_n_o=0, wr_n_o=1, data already driven. The strobe falls on the next clock.
- R3: wr_n_o stays low for n clocks, where n is strobe_len_i sampled at acceptance. A value of 0 is treated as 1.
- R4: After wr_n_o rises, cs_n_o stays low and the data stays unchanged for m clocks, where m is hold_len_i sampled at acceptance. With m=0 the transfer ends at the strobe's rising edge.
- R5: Format code 0, and reserved code 3, put the input word unchanged on d_o[15:0]. In these formats the extension bus is not driven.
- R6: Format code 1 widens the pixel to an 18-bit word w = {r5,r5[4], g6, b5,b5[4]}. The input is {r5,g6,b5} with red in bits 15:11. The block drives d_o=w[15:0], ext_o=w[17:16] and ext_oe_o=1.
- R7: Format code 2 sends w in two complete transfers, w[17:9] first and then w[8:0]. Each half goes on d_o[8:0], with d_o[15:9]=0 and the extension bus not driven. The second transfer's setup clock follows straight after the first one's hold period.
- R8: pix_ready_o is 1 only when idle. Once a pixel is accepted, the next one cannot start until the last hold period has ended, and at least one idle clock with cs_n_o=1 always comes between them.
- R9: The format, n, m and pixel are sampled when the pixel is accepted. Changing those inputs during a transfer has no effect on it.
- R10: dc_o is 1 in every clock where cs_n_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel available |
| pix_data_i | input | 16 | RGB565 pixel |
| pix_ready_o | output | 1 | Pixel accepted when high together with valid |
| fmt_i | input | 2 | Output format: 0 16-bit, 1 18-bit, 2 two 9-bit halves, 3 as 0 |
| strobe_len_i | input | 4 | Strobe width n in clocks (0 acts as 1) |
| hold_len_i | input | 4 | Hold time m in clocks |
| dc_o | output | 1 | Command/data select, 1 for pixel data |
| cs_n_o | output | 1 | Chip select, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| d_o | output | 16 | Display data value |
| d_oe_o | output | 1 | Display data drive enable |
| ext_o | output | 2 | Extension data value |
| ext_oe_o | output | 1 | Extension data drive enable |

## Verification
Assertions check four rules on every clock. A falling strobe must come right after a setup clock. The strobe width must equal the sampled n. Select and data must stay steady outside setup clocks. The data/command line must be high, and ready low, while the chip is selected. Other behaviour can only be shown by the bench's scenarios, because checking it needs the expected pixel values. That covers the exact hold length, the widening of RGB565, the order of the split halves, the idle gap between pixels, and the rule that register changes made mid-transfer have no effect.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  typedef enum logic [1:0] {
    FMT_16  = 2'd0,
    FMT_18  = 2'd1,
    FMT_9X2 = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  localparam int unsigned R_W  = 5;
  localparam int unsigned G_W  = 6;
  localparam int unsigned B_W  = 5;
  localparam int unsigned IN_W = R_W + G_W + B_W;
  localparam int unsigned WD_W = IN_W + 2;

  // 565 -> 666: replicate red/blue MSB into the new LSB
  function automatic logic [WD_W-1:0] widen(input logic [IN_W-1:0] p);
    logic [R_W-1:0] r;
    logic [G_W-1:0] g;
    logic [B_W-1:0] b;
    {r, g, b} = p;
    return {r, r[R_W-1], g, b, b[B_W-1]};
  endfunction
endpackage

// File: rtl/dwc_beat_fmt.sv
module dwc_beat_fmt
  import dwc_pkg::*;
#(
  parameter int unsigned BUS_W = 16,
  parameter int unsigned EXT_W = 2
) (
  input  logic [IN_W-1:0]  pix_i,
  input  fmt_e             fmt_i,
  output logic [BUS_W-1:0] beat0_o,
  output logic [BUS_W-1:0] beat1_o,
  output logic [EXT_W-1:0] ext_o,
  output logic             ext_en_o,
  output logic             two_beats_o
);
  localparam int unsigned HALF_W = WD_W / 2;

  logic [WD_W-1:0] wide;
  assign wide = widen(pix_i);

  always_comb begin
    beat0_o     = '0;
    beat1_o     = '0;
    ext_o       = '0;
    ext_en_o    = 1'b0;
    two_beats_o = 1'b0;
    unique case (fmt_i)
      FMT_18: begin
        beat0_o  = wide[BUS_W-1:0];
        ext_o    = wide[WD_W-1:BUS_W];
        ext_en_o = 1'b1;
      end
      FMT_9X2: begin
        beat0_o[HALF_W-1:0] = wide[WD_W-1:HALF_W];
        beat1_o[HALF_W-1:0] = wide[HALF_W-1:0];
        two_beats_o         = 1'b1;
      end
      default: beat0_o = pix_i;
    endcase
  end
endmodule

// File: rtl/dwc_seq.sv
module dwc_seq
  import dwc_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic [CNT_W-1:0] m_i,
  input  logic             two_beats_i,
  output phase_e           phase_o,
  output logic             beat_sel_o,
  output logic             idle_o
);
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             beat_q, beat_d;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    beat_d = beat_q;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        ph_d   = PH_SETUP;
        beat_d = 1'b0;
      end
      PH_SETUP: begin
        ph_d  = PH_STROBE;
        cnt_d = n_i - 1'b1;
      end
      PH_STROBE: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else if (m_i != '0) begin
          ph_d  = PH_HOLD;
          cnt_d = m_i - 1'b1;
        end else if (two_beats_i && !beat_q) begin
          ph_d   = PH_SETUP;
          beat_d = 1'b1;
        end else ph_d = PH_IDLE;
      end
      PH_HOLD: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else if (two_beats_i && !beat_q) begin
          ph_d   = PH_SETUP;
          beat_d = 1'b1;
        end else ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      beat_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      beat_q <= beat_d;
    end
  end

  assign phase_o    = ph_q;
  assign beat_sel_o = beat_q;
  assign idle_o     = (ph_q == PH_IDLE);

  // a strobe is always preceded by a setup clock
  p_setup_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_STROBE && $past(ph_q) != PH_STROBE) |-> $past(ph_q) == PH_SETUP);
  // no hold phase when m is zero
  p_no_hold_m0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_HOLD) |-> (m_i != '0));
endmodule

// File: rtl/disp_wr_gen.sv
module disp_wr_gen
  import dwc_pkg::*;
#(
  parameter int unsigned BUS_W = 16,
  parameter int unsigned EXT_W = 2,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_valid_i,
  input  logic [IN_W-1:0]  pix_data_i,
  output logic             pix_ready_o,
  input  logic [1:0]       fmt_i,
  input  logic [CNT_W-1:0] strobe_len_i,
  input  logic [CNT_W-1:0] hold_len_i,
  output logic             dc_o,
  output logic             cs_n_o,
  output logic             wr_n_o,
  output logic [BUS_W-1:0] d_o,
  output logic             d_oe_o,
  output logic [EXT_W-1:0] ext_o,
  output logic             ext_oe_o
);
  logic [IN_W-1:0]  pix_q;
  fmt_e             fmt_q;
  logic [CNT_W-1:0] n_q, m_q;
  logic             accept, idle, beat_sel, two_beats, ext_en;
  logic [BUS_W-1:0] beat0, beat1;
  logic [EXT_W-1:0] ext_val;
  phase_e           phase;

  assign accept = pix_valid_i && idle;

  // sample everything at acceptance; n=0 is promoted to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q <= '0;
      fmt_q <= FMT_16;
      n_q   <= CNT_W'(1);
      m_q   <= '0;
    end else if (accept) begin
      pix_q <= pix_data_i;
      fmt_q <= fmt_e'(fmt_i);
      n_q   <= (strobe_len_i == '0) ? CNT_W'(1) : strobe_len_i;
      m_q   <= hold_len_i;
    end
  end

  dwc_beat_fmt #(.BUS_W(BUS_W), .EXT_W(EXT_W)) i_fmt (
    .pix_i       (pix_q),
    .fmt_i       (fmt_q),
    .beat0_o     (beat0),
    .beat1_o     (beat1),
    .ext_o       (ext_val),
    .ext_en_o    (ext_en),
    .two_beats_o (two_beats)
  );

  dwc_seq #(.CNT_W(CNT_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .n_i         (n_q),
    .m_i         (m_q),
    .two_beats_i (two_beats),
    .phase_o     (phase),
    .beat_sel_o  (beat_sel),
    .idle_o      (idle)
  );

  logic active;
  assign active      = !idle;
  assign pix_ready_o = idle;
  assign cs_n_o      = !active;
  assign dc_o        = active;
  assign wr_n_o      = (phase != PH_STROBE);
  assign d_oe_o      = active;
  assign d_o         = active ? (beat_sel ? beat1 : beat0) : '0;
  assign ext_oe_o    = active && ext_en;
  assign ext_o       = ext_oe_o ? ext_val : '0;

  // strobe width monitor
  logic [CNT_W:0] wr_lo_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wr_lo_cnt <= '0;
    else if (!wr_n_o) wr_lo_cnt <= wr_lo_cnt + 1'b1;
    else              wr_lo_cnt <= '0;
  end

  p_strobe_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_n_o) |-> (wr_lo_cnt == {1'b0, n_q}));
  p_strobe_under_cs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |-> !cs_n_o);
  p_data_steady_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && phase != PH_SETUP) |-> ($stable(d_o) && $stable(ext_o)));
  p_dc_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> dc_o);
  p_busy_not_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> !pix_ready_o);
  p_ext_with_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_oe_o |-> d_oe_o);
endmodule

// File: tb/test_disp_wr_gen.sv
module test_disp_wr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] pix = '0;
  logic [1:0]  fmt = '0;
  logic [3:0]  n_r = 4'd1;
  logic [3:0]  m_r = '0;
  logic        ready, dc, cs_n, wr_n, d_oe, ext_oe;
  logic [15:0] d;
  logic [1:0]  ext;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  disp_wr_gen i_disp_wr_gen (
    .clk_i(clk), .rst_ni(rst_n), .pix_valid_i(valid), .pix_data_i(pix),
    .pix_ready_o(ready), .fmt_i(fmt), .strobe_len_i(n_r), .hold_len_i(m_r),
    .dc_o(dc), .cs_n_o(cs_n), .wr_n_o(wr_n), .d_o(d), .d_oe_o(d_oe),
    .ext_o(ext), .ext_oe_o(ext_oe)
  );

  // {dc, cs_n, wr_n, ready, d_oe, ext_oe, d, ext}
  function automatic logic [23:0] pins();
    return {dc, cs_n, wr_n, ready, d_oe, ext_oe, d, ext};
  endfunction

  function automatic logic [17:0] wide(input logic [15:0] p);
    return {p[15:11], p[15], p[10:5], p[4:0], p[4]};
  endfunction

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  localparam logic [23:0] IDLE_PINS = {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0, 2'b0};

  // send one pixel and check every clock until idle again
  task automatic send_px(input string tag, input logic [1:0] f, input logic [3:0] n,
                         input logic [3:0] m, input logic [15:0] p, input bit scramble);
    logic [17:0] w;
    logic [15:0] dv [2];
    logic [1:0]  ev;
    bit          eo;
    int          beats, ne;
    w     = wide(p);
    ne    = (n == 0) ? 1 : int'(n);
    beats = (f == 2'd2) ? 2 : 1;
    ev    = 2'b0;
    eo    = 1'b0;
    dv[1] = '0;
    case (f)
      2'd1: begin dv[0] = w[15:0]; ev = w[17:16]; eo = 1'b1; end
      2'd2: begin dv[0] = {7'b0, w[17:9]}; dv[1] = {7'b0, w[8:0]}; end
      default: dv[0] = p;
    endcase
    @(negedge clk);
    fmt = f; n_r = n; m_r = m; pix = p; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    if (scramble) begin
      fmt = ~f; n_r = n + 4'd3; m_r = m + 4'd2; pix = ~p;
    end
    for (int b = 0; b < beats; b++) begin
      for (int t = 0; t < 1 + ne + int'(m); t++) begin
        bit lo;
        string ph;
        lo = (t >= 1) && (t <= ne);
        ph = (t == 0) ? "R2" : (lo ? "R3" : "R4");
        chk({ph, " R8 R10 ", tag}, pins(),
            {1'b1, 1'b0, ~lo, 1'b0, 1'b1, eo, dv[b], ev});
        @(negedge clk);
      end
    end
    chk({"R1 R8 end ", tag}, pins(), IDLE_PINS);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", pins(), IDLE_PINS);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", pins(), IDLE_PINS);
  endtask

  task automatic t_fmt16();  send_px("R5 fmt0", 2'd0, 4'd2, 4'd1, 16'hA5C3, 0); endtask
  task automatic t_fmt18();  send_px("R6 fmt1", 2'd1, 4'd3, 4'd0, 16'hF81F, 0); endtask
  task automatic t_split();  send_px("R7 fmt2", 2'd2, 4'd1, 4'd2, 16'h07E0, 0); endtask
  task automatic t_n_zero(); send_px("R3 n0",   2'd0, 4'd0, 4'd0, 16'h1234, 0); endtask
  task automatic t_rsv();    send_px("R5 fmt3", 2'd3, 4'd2, 4'd2, 16'hBEEF, 0); endtask
  task automatic t_latch();  send_px("R9 scr",  2'd1, 4'd2, 4'd2, 16'h8410, 1); endtask
  task automatic t_long();   send_px("R7 long", 2'd2, 4'd5, 4'd4, 16'h6B4D, 0); endtask

  // back-to-back: valid held high; an idle clock must separate pixels
  task automatic t_b2b();
    @(negedge clk);
    fmt = 2'd0; n_r = 4'd1; m_r = 4'd0; pix = 16'h0F0F; valid = 1'b1;
    @(negedge clk);
    chk("R8 b2b first setup", pins(), {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0F0F, 2'b0});
    @(negedge clk);
    @(negedge clk);
    chk("R8 b2b gap", pins(), IDLE_PINS);
    pix = 16'hF0F0;
    @(negedge clk);
    valid = 1'b0;
    chk("R8 b2b second setup", pins(), {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'hF0F0, 2'b0});
    repeat (2) @(negedge clk);
    chk("R1 b2b end", pins(), IDLE_PINS);
  endtask

  initial begin
    t_reset();
    t_fmt16();
    t_fmt18();
    t_split();
    t_n_zero();
    t_rsv();
    t_latch();
    t_long();
    t_b2b();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule